// File: doc/BRIEF.md
# Two-Stage Trigger Readout Buffer

This block sits in the front end of a detector module that runs under two trigger levels. Every clock cycle is one bunch crossing. The sample of every crossing goes into a primary ring pipeline that is deep enough to cover the first-level decision latency. When a first-level accept arrives, the crossing captured `L0_LAT` cycles earlier is copied into a small secondary store. The copy carries an event tag taken from a running accept counter. If the accept also flags this module as part of a region of interest, a short partial frame with the first `SUB` channels goes out at once.

Second-level decisions come later and carry the event tag. They are matched in arrival order against the oldest secondary entry that has no decision yet. A keep decision sends the whole event, `NCH` channels, as a full frame. A discard decision frees the slot silently. Both frame kinds leave through one valid/ready stream port. Each frame starts with a header word and ends with an `out_last` marker. The port holds its word while `out_ready` is low, and a frame is never interleaved with another. A full readout takes precedence whenever the output is between frames.

Top module: `trig_readout_buf`

## Requirements
- R1: Every cycle out of reset stores `bx_data` in the primary pipeline. A first-level accept in cycle t captures the crossing sampled in cycle t-`L0_LAT` (default 10). Channel k is `bx_data[k*DW +: DW]`.
- R2: `evt_tag` starts at 0 and increments by one, wrapping, on every first-level accept, including dropped ones. A stored event takes the value `evt_tag` had in its accept cycle.
- R3: An accepted event whose `l0_region` was 1 produces a partial frame: one header word followed by channels 0 to `SUB`-1 (default 2).
- R4: A second-level message with `l1_valid`=1 and `l1_keep`=1, whose `l1_tag` equals the tag of the oldest undecided entry, produces a full frame: one header followed by channels 0 to `NCH`-1 (default 4). The slot is freed after the frame's last word.
- R5: A matching message with `l1_keep`=0 frees the slot without any output. A message whose tag does not match the oldest undecided entry, or that arrives when every entry is already decided, changes nothing.
- R6: `busy` is 1 exactly while all `SLOTS` (default 4) secondary slots are occupied. A first-level accept while `busy` is 1 stores nothing and increments `drop_cnt` by one.
- R7: Frame starts are chosen only between frames. A decided-keep oldest entry goes first, otherwise the oldest entry with a pending partial. Starting a full frame cancels that event's own pending partial. A slot that still owes a partial frame is not freed.
- R8: Header word format: bit `DW`-1 is 1 for a full frame and 0 for a partial frame, bits `TW`-1..0 hold the event tag, and all other bits are 0. `out_first` marks the header and `out_last` marks the final word.
- R9: While `out_valid`=1 and `out_ready`=0, `out_valid`, `out_data`, `out_first` and `out_last` hold their values. A word is consumed on a cycle with both high.
- R10: After reset, `out_valid`, `busy`, `drop_cnt` and `evt_tag` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Crossing clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bx_data | input | NCH*DW | Sample of the current crossing |
| l0_acc | input | 1 | First-level accept |
| l0_region | input | 1 | Region-of-interest flag for this module, valid with l0_acc |
| l1_valid | input | 1 | Second-level decision strobe |
| l1_keep | input | 1 | 1 keep (read out), 0 discard |
| l1_tag | input | TW | Tag of the event the decision refers to |
| out_valid | output | 1 | Output word valid |
| out_ready | input | 1 | Downstream accepts the word |
| out_data | output | DW | Header or channel word |
| out_first | output | 1 | Word is a frame header |
| out_last | output | 1 | Word ends a frame |
| busy | output | 1 | Secondary store full |
| drop_cnt | output | CW | Count of accepts lost to a full store |
| evt_tag | output | TW | Tag the next first-level accept receives |

## Verification
The hardest state to reach is a full secondary store in which partial frames are still owed while later accepts keep arriving. In that state a keep decision must overtake an older pending partial, and a discarded slot must wait for its partial before it is freed. The stimulus reaches it by starving second-level decisions and holding `out_ready` mostly low while region-flagged accepts arrive at a high rate. It then releases decisions in bursts with random keep and discard choices and occasional wrong tags. A behavioural queue model predicts every output word in every cycle.

// File: rtl/rb_pkg.sv
package rb_pkg;
  typedef enum logic [1:0] {
    SL_HELD = 2'd0,
    SL_KEEP = 2'd1,
    SL_DROP = 2'd2
  } slot_st_t;
endpackage

// File: rtl/rb_pipe.sv
// Primary ring: one write per crossing, fixed-latency read tap.
module rb_pipe #(
  parameter int W     = 64,
  parameter int DEPTH = 16,
  parameter int LAT   = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int AW = $clog2(DEPTH);

  logic [W-1:0]  ring [DEPTH];
  logic [AW-1:0] wp;

  always_ff @(posedge clk) begin
    ring[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp <= '0;
    else        wp <= wp + 1'b1;
  end

  assign dout = ring[wp - AW'(LAT)];
endmodule

// File: rtl/rb_slots.sv
// Secondary store: ring of slots with write, decision and retire pointers.
module rb_slots import rb_pkg::*; #(
  parameter int W     = 64,
  parameter int SLOTS = 4,
  parameter int TW    = 8,
  parameter int CW    = 8
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     l0_acc,
  input  logic                     l0_region,
  input  logic [W-1:0]             l0_data,
  input  logic                     l1_valid,
  input  logic                     l1_keep,
  input  logic [TW-1:0]            l1_tag,
  input  logic                     start_full,
  input  logic                     done_full,
  input  logic                     done_part,
  input  logic [$clog2(SLOTS)-1:0] part_done_idx,
  input  logic [$clog2(SLOTS)-1:0] rd_idx,
  output logic [W-1:0]             rd_data,
  output logic [TW-1:0]            rd_tag,
  output logic [$clog2(SLOTS)-1:0] head_idx,
  output logic                     head_keep,
  output logic                     part_any,
  output logic [$clog2(SLOTS)-1:0] part_idx,
  output logic                     full,
  output logic [CW-1:0]            drop_cnt,
  output logic [TW-1:0]            evt_tag
);
  localparam int SW = $clog2(SLOTS);
  localparam int PW = SW + 1;

  logic [W-1:0]     data_q [SLOTS];
  logic [TW-1:0]    tag_q  [SLOTS];
  slot_st_t         st_q   [SLOTS];
  logic [SLOTS-1:0] pend_q, pend_nx;
  logic [PW-1:0]    wr_p, rd_p, dc_p, fill;
  logic [SW-1:0]    wr_i, rd_i, dc_i;
  logic             store, l1_hit, head_dec, head_free, retire;

  assign wr_i = wr_p[SW-1:0];
  assign rd_i = rd_p[SW-1:0];
  assign dc_i = dc_p[SW-1:0];
  assign fill = wr_p - rd_p;
  assign full = (fill == PW'(SLOTS));

  assign store     = l0_acc & ~full;
  assign l1_hit    = l1_valid & (dc_p != wr_p) & (l1_tag == tag_q[dc_i]);
  assign head_dec  = (rd_p != dc_p);
  assign head_keep = head_dec & (st_q[rd_i] == SL_KEEP);
  assign head_free = head_dec & (st_q[rd_i] == SL_DROP) & ~pend_q[rd_i];
  assign retire    = done_full | head_free;
  assign head_idx  = rd_i;

  assign rd_data = data_q[rd_idx];
  assign rd_tag  = tag_q[rd_idx];

  // oldest pending partial, scanning from the retire pointer
  always_comb begin
    part_any = 1'b0;
    part_idx = '0;
    for (int k = SLOTS - 1; k >= 0; k--) begin
      logic [SW-1:0] ix;
      ix = rd_i + SW'(k);
      if (pend_q[ix]) begin
        part_any = 1'b1;
        part_idx = ix;
      end
    end
  end

  always_comb begin
    pend_nx = pend_q;
    if (done_part)         pend_nx[part_done_idx] = 1'b0;
    if (start_full)        pend_nx[rd_i]          = 1'b0;
    if (store & l0_region) pend_nx[wr_i]          = 1'b1;
  end

  always_ff @(posedge clk) begin
    if (store) begin
      data_q[wr_i] <= l0_data;
      tag_q[wr_i]  <= evt_tag;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_p     <= '0;
      rd_p     <= '0;
      dc_p     <= '0;
      pend_q   <= '0;
      drop_cnt <= '0;
      evt_tag  <= '0;
      for (int s = 0; s < SLOTS; s++) st_q[s] <= SL_HELD;
    end else begin
      pend_q <= pend_nx;
      if (store) begin
        wr_p       <= wr_p + 1'b1;
        st_q[wr_i] <= SL_HELD;
      end
      if (l1_hit) begin
        dc_p       <= dc_p + 1'b1;
        st_q[dc_i] <= l1_keep ? SL_KEEP : SL_DROP;
      end
      if (retire)         rd_p     <= rd_p + 1'b1;
      if (l0_acc)         evt_tag  <= evt_tag + 1'b1;
      if (l0_acc && full) drop_cnt <= drop_cnt + 1'b1;
    end
  end
endmodule

// File: rtl/rb_framer.sv
// Output framer: chooses the next frame between frames, streams header + channels.
module rb_framer #(
  parameter int DW  = 16,
  parameter int NCH = 4,
  parameter int SUB = 2,
  parameter int TW  = 8,
  parameter int SW  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              head_keep,
  input  logic [SW-1:0]     head_idx,
  input  logic              part_any,
  input  logic [SW-1:0]     part_idx,
  input  logic [NCH*DW-1:0] rd_data,
  input  logic [TW-1:0]     rd_tag,
  output logic [SW-1:0]     rd_idx,
  output logic              start_full,
  output logic              done_full,
  output logic              done_part,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_first,
  output logic              out_last
);
  localparam int IW = $clog2(NCH + 1);
  localparam int NW = 1 << IW;
  localparam logic [IW-1:0] LAST_F = IW'(NCH);
  localparam logic [IW-1:0] LAST_P = IW'(SUB);

  logic          act_q, full_q, hs, start_part;
  logic [SW-1:0] idx_q;
  logic [IW-1:0] wd_q, ch_sel;
  logic [DW-1:0] ch [NW];
  logic [DW-1:0] hdr;

  for (genvar g = 0; g < NW; g++) begin : g_ch
    if (g < NCH) begin : g_real
      assign ch[g] = rd_data[g*DW +: DW];
    end else begin : g_pad
      assign ch[g] = '0;
    end
  end

  always_comb begin
    hdr         = '0;
    hdr[DW-1]   = full_q;
    hdr[TW-1:0] = rd_tag;
  end

  assign rd_idx     = idx_q;
  assign start_full = ~act_q & head_keep;
  assign start_part = ~act_q & ~head_keep & part_any;
  assign out_valid  = act_q;
  assign out_first  = act_q & (wd_q == '0);
  assign out_last   = act_q & (wd_q == (full_q ? LAST_F : LAST_P));
  assign ch_sel     = wd_q - 1'b1;
  assign out_data   = (wd_q == '0) ? hdr : ch[ch_sel];
  assign hs         = act_q & out_ready;
  assign done_full  = hs & out_last & full_q;
  assign done_part  = hs & out_last & ~full_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      full_q <= 1'b0;
      idx_q  <= '0;
      wd_q   <= '0;
    end else if (!act_q) begin
      if (start_full) begin
        act_q  <= 1'b1;
        full_q <= 1'b1;
        idx_q  <= head_idx;
        wd_q   <= '0;
      end else if (start_part) begin
        act_q  <= 1'b1;
        full_q <= 1'b0;
        idx_q  <= part_idx;
        wd_q   <= '0;
      end
    end else if (hs) begin
      if (out_last) act_q <= 1'b0;
      else          wd_q  <= wd_q + 1'b1;
    end
  end
endmodule

// File: rtl/trig_readout_buf.sv
module trig_readout_buf #(
  parameter int DW     = 16,
  parameter int NCH    = 4,
  parameter int SUB    = 2,
  parameter int TW     = 8,
  parameter int CW     = 8,
  parameter int SLOTS  = 4,
  parameter int DEPTH  = 16,
  parameter int L0_LAT = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NCH*DW-1:0] bx_data,
  input  logic              l0_acc,
  input  logic              l0_region,
  input  logic              l1_valid,
  input  logic              l1_keep,
  input  logic [TW-1:0]     l1_tag,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DW-1:0]     out_data,
  output logic              out_first,
  output logic              out_last,
  output logic              busy,
  output logic [CW-1:0]     drop_cnt,
  output logic [TW-1:0]     evt_tag
);
  localparam int EW = NCH * DW;
  localparam int SW = $clog2(SLOTS);

  logic [EW-1:0] tap, rd_data;
  logic [TW-1:0] rd_tag;
  logic [SW-1:0] rd_idx, head_idx, part_idx;
  logic          head_keep, part_any, start_full, done_full, done_part;

  rb_pipe #(.W(EW), .DEPTH(DEPTH), .LAT(L0_LAT)) u_pipe (
    .clk(clk), .rst_n(rst_n), .din(bx_data), .dout(tap)
  );

  rb_slots #(.W(EW), .SLOTS(SLOTS), .TW(TW), .CW(CW)) u_slots (
    .clk(clk), .rst_n(rst_n),
    .l0_acc(l0_acc), .l0_region(l0_region), .l0_data(tap),
    .l1_valid(l1_valid), .l1_keep(l1_keep), .l1_tag(l1_tag),
    .start_full(start_full), .done_full(done_full), .done_part(done_part),
    .part_done_idx(rd_idx), .rd_idx(rd_idx), .rd_data(rd_data), .rd_tag(rd_tag),
    .head_idx(head_idx), .head_keep(head_keep),
    .part_any(part_any), .part_idx(part_idx),
    .full(busy), .drop_cnt(drop_cnt), .evt_tag(evt_tag)
  );

  rb_framer #(.DW(DW), .NCH(NCH), .SUB(SUB), .TW(TW), .SW(SW)) u_framer (
    .clk(clk), .rst_n(rst_n),
    .head_keep(head_keep), .head_idx(head_idx),
    .part_any(part_any), .part_idx(part_idx),
    .rd_data(rd_data), .rd_tag(rd_tag), .rd_idx(rd_idx),
    .start_full(start_full), .done_full(done_full), .done_part(done_part),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last)
  );
endmodule

// File: rtl/rb_chk.sv
module rb_chk #(
  parameter int DW = 16,
  parameter int TW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          l0_acc,
  input logic          out_valid,
  input logic          out_ready,
  input logic [DW-1:0] out_data,
  input logic          out_first,
  input logic          out_last,
  input logic          busy,
  input logic [CW-1:0] drop_cnt,
  input logic [TW-1:0] evt_tag
);
  // R9
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_first) && $stable(out_last));

  // R6
  drop_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l0_acc && busy |=> drop_cnt == $past(drop_cnt) + CW'(1));

  // R6
  drop_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(l0_acc && busy) |=> $stable(drop_cnt));

  // R2
  tag_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    l0_acc |=> evt_tag == $past(evt_tag) + TW'(1));

  // R2
  tag_still_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !l0_acc |=> $stable(evt_tag));

  // R8
  frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_first && out_last));

  // R8
  hdr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_first |-> out_data[DW-2:TW] == '0);
endmodule

bind trig_readout_buf rb_chk #(.DW(DW), .TW(TW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .l0_acc(l0_acc),
  .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
  .out_first(out_first), .out_last(out_last),
  .busy(busy), .drop_cnt(drop_cnt), .evt_tag(evt_tag)
);

// File: tb/trig_readout_buf_test.sv
`timescale 1ns/1ps
module trig_readout_buf_test;
  localparam int DW = 16, NCH = 4, SUB = 2, TW = 8, CW = 8, SLOTS = 4, LAT = 10;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [NCH*DW-1:0] bx_data = '0;
  logic l0_acc = 0, l0_region = 0, l1_valid = 0, l1_keep = 0, out_ready = 0;
  logic [TW-1:0] l1_tag = '0;
  logic out_valid, out_first, out_last, busy;
  logic [DW-1:0] out_data;
  logic [CW-1:0] drop_cnt;
  logic [TW-1:0] evt_tag;

  always #4 clk = ~clk;

  trig_readout_buf uut (
    .clk(clk), .rst_n(rst_n), .bx_data(bx_data), .l0_acc(l0_acc), .l0_region(l0_region),
    .l1_valid(l1_valid), .l1_keep(l1_keep), .l1_tag(l1_tag),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_first(out_first), .out_last(out_last),
    .busy(busy), .drop_cnt(drop_cnt), .evt_tag(evt_tag)
  );

  typedef struct { int tag; logic [NCH*DW-1:0] d; int st; bit pend; } ent_t;
  ent_t q[$];
  logic [NCH*DW-1:0] hist[$];
  bit m_act, m_full;
  int m_tag, m_wd, m_drop, m_evt;
  int n_full, n_part, n_rej, n_preempt;
  int tests, fails;
  bit done;

  // behavioural reference: all decisions from pre-edge state
  always @(posedge clk) begin
    if (!rst_n) begin
      q.delete(); hist.delete();
      m_act = 0; m_full = 0; m_tag = 0; m_wd = 0; m_drop = 0; m_evt = 0;
    end else begin
      int sz, pidx, u, lastn;
      bit hs, lastw, dfull, dpart, hkeep, hrej, l1hit;
      sz = q.size();
      lastn = m_full ? NCH : SUB;
      hs = m_act && out_ready;
      lastw = (m_wd == lastn);
      dfull = hs && lastw && m_full;
      dpart = hs && lastw && !m_full;
      hkeep = sz > 0 && q[0].st == 1;
      hrej = sz > 0 && q[0].st == 2 && !q[0].pend;
      pidx = -1;
      for (int i = 0; i < sz; i++) if (q[i].pend) begin pidx = i; break; end
      u = -1;
      for (int i = 0; i < sz; i++) if (q[i].st == 0) begin u = i; break; end
      l1hit = l1_valid && u >= 0 && q[u].tag == int'(l1_tag);
      if (!m_act) begin
        if (hkeep) begin
          if (pidx >= 0) n_preempt++;
          m_act = 1; m_full = 1; m_tag = q[0].tag; m_wd = 0; q[0].pend = 0; n_full++;
        end else if (pidx >= 0) begin
          m_act = 1; m_full = 0; m_tag = q[pidx].tag; m_wd = 0; n_part++;
        end
      end else if (hs) begin
        if (lastw) begin
          m_act = 0;
          if (dpart) foreach (q[i]) if (q[i].tag == m_tag) q[i].pend = 0;
        end else m_wd++;
      end
      if (l1hit) begin
        q[u].st = l1_keep ? 1 : 2;
        if (!l1_keep) n_rej++;
      end
      if (dfull || hrej) void'(q.pop_front());
      if (l0_acc) begin
        if (sz == SLOTS) m_drop = (m_drop + 1) % 256;
        else begin
          ent_t e;
          e.tag = m_evt; e.d = hist[hist.size() - LAT]; e.st = 0; e.pend = l0_region;
          q.push_back(e);
        end
        m_evt = (m_evt + 1) % 256;
      end
      hist.push_back(bx_data);
    end
  end

  task automatic fail_msg(string rq, string what, int act, int exp);
    $display("FAIL %s %s actual=%0h expected=%0h", rq, what, act, exp);
  endtask

  task automatic compare();
    bit bad;
    logic [DW-1:0] ed;
    bit ef, el;
    bad = 0; ed = '0; ef = 0; el = 0;
    tests++;
    if (m_act) begin
      int ix;
      ix = -1;
      foreach (q[i]) if (q[i].tag == m_tag) ix = i;
      ef = (m_wd == 0);
      el = (m_wd == (m_full ? NCH : SUB));
      if (ef) begin ed = '0; ed[DW-1] = m_full; ed[TW-1:0] = m_tag[TW-1:0]; end
      else if (ix >= 0) ed = q[ix].d[(m_wd-1)*DW +: DW];
    end
    if (out_valid !== m_act) begin bad = 1; fail_msg("R7", "out_valid", out_valid, m_act); end
    if (m_act) begin
      if (out_data !== ed) begin
        bad = 1; fail_msg(ef ? "R8" : (m_full ? "R4" : "R3"), "out_data", out_data, ed);
      end
      if (out_first !== ef || out_last !== el) begin
        bad = 1; fail_msg("R8", "first/last", {out_first, out_last}, {ef, el});
      end
    end
    if (busy !== (q.size() == SLOTS)) begin bad = 1; fail_msg("R6", "busy", busy, q.size() == SLOTS); end
    if (drop_cnt !== CW'(m_drop)) begin bad = 1; fail_msg("R6", "drop_cnt", drop_cnt, m_drop); end
    if (evt_tag !== TW'(m_evt)) begin bad = 1; fail_msg("R2", "evt_tag", evt_tag, m_evt); end
    if (bad) fails++;
  endtask

  task automatic run(int cycles, int p_l0, int p_reg, int p_rdy, int p_l1, int p_keep);
    for (int c = 0; c < cycles; c++) begin
      @(negedge clk);
      compare();   // R1 R3 R4 R5 R7 R8 R9 through per-cycle match
      bx_data   = {$urandom, $urandom};
      l0_acc    = ($urandom % 100) < p_l0;
      l0_region = ($urandom % 100) < p_reg;
      out_ready = ($urandom % 100) < p_rdy;
      l1_valid = 0; l1_keep = 0; l1_tag = '0;
      if (($urandom % 100) < p_l1) begin
        int u;
        u = -1;
        foreach (q[i]) if (u < 0 && q[i].st == 0) u = i;
        l1_valid = 1;
        l1_keep  = ($urandom % 100) < p_keep;
        if (u >= 0) l1_tag = TW'(q[u].tag + ((($urandom % 10) == 0) ? 1 : 0)); // R5 wrong tag now and then
        else        l1_tag = TW'($urandom);
      end
    end
  endtask

  task automatic tally(bit ok, string rq, string what, int act, int exp);
    tests++;
    if (!ok) begin fails++; fail_msg(rq, what, act, exp); end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R10 reset state
    tally(out_valid === 1'b0, "R10", "out_valid", out_valid, 0);
    tally(busy === 1'b0, "R10", "busy", busy, 0);
    tally(drop_cnt === '0, "R10", "drop_cnt", drop_cnt, 0);
    tally(evt_tag === '0, "R10", "evt_tag", evt_tag, 0);
    rst_n = 1'b1;
    run(20, 0, 0, 100, 0, 0);        // R1 fill pipeline
    run(3000, 20, 50, 70, 30, 60);   // mixed traffic
    run(1500, 40, 80, 20, 2, 50);    // R6 R7 congestion, decisions starved
    run(800, 5, 50, 100, 60, 50);    // drain
    run(200, 30, 100, 0, 10, 80);    // R9 stalled output
    run(2000, 25, 40, 60, 40, 50);
    run(300, 0, 0, 100, 80, 50);
    tally(n_full > 0, "R4", "full frames", n_full, 1);
    tally(n_part > 0, "R3", "partial frames", n_part, 1);
    tally(n_rej > 0, "R5", "discards", n_rej, 1);
    tally(m_drop > 0, "R6", "drops", m_drop, 1);
    tally(n_preempt > 0, "R7", "full over pending partial", n_preempt, 1);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule